// File: doc/BRIEF.md
# Memory Request Error Detector

This block sits on the request path between an interconnect port and a memory controller core. Each read or write request from the interconnect is checked on its first cycle. A request that arrives while the memory is in deep power-down is answered at once with an error response and never reaches the core. A request whose address lies outside the window programmed for its initiator is flagged, and its address is recorded. A request that the core leaves unaccepted for a programmable number of cycles is flagged as a timeout.

Every error sets a sticky valid flag and records a 2-bit error kind. The flag stays set until software pulses a write-one-to-clear strobe. Only an out-of-window access updates the captured address, so the register always holds the address of the latest illegal access. Requests that pass the power check are forwarded unchanged, and the core's accept is returned to the requester in the same cycle.

Top module: `mreq_err_guard`

## Requirements
- R1: A request presented while `pwr_deep_down` is low is driven to the core in the same cycle with the same address and direction, and `core_req_accept` is returned on `up_req_accept` in that cycle.
- R2: A request whose first cycle sees `pwr_deep_down` high gets `up_req_accept`=1 and `up_resp_err`=1 in that cycle, with `core_req_valid`=0. One cycle later `err_kind` reads 2'b01 (power-down access).
- R3: Initiator i owns the inclusive window lo..hi, where lo is bits [i*ADDR_W +: ADDR_W] of `win_lo` and hi is the same slice of `win_hi`. A request outside its initiator's window is still forwarded. One cycle after its first cycle, `err_kind` reads 2'b10 and `err_addr` holds its address.
- R4: A later out-of-window access overwrites `err_addr`. Legal accesses, power-down errors and timeouts leave `err_addr` unchanged.
- R5: With `cfg_timeout`=T>0, a request that stays unaccepted for T consecutive cycles raises `err_kind`=2'b11 one cycle later, once per request. A request accepted in its T-th cycle raises no error.
- R6: With `cfg_timeout`=0 the timeout check is off, however long a request waits.
- R7: Any error sets `err_valid`, which stays set until a cycle with `sw_clr`=1. When an error and `sw_clr` fall in the same cycle, the error wins and `err_valid` stays 1. `err_kind` always shows the latest error.
- R8: After reset `err_valid`=0, `err_kind`=2'b00 and `err_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_req_valid | input | 1 | Request present from the interconnect |
| up_req_write | input | 1 | 1 = write, 0 = read |
| up_req_addr | input | ADDR_W | Request address |
| up_req_init | input | ID_W | Initiator index |
| up_req_accept | output | 1 | Request accepted |
| up_resp_err | output | 1 | Error completion (power-down access) |
| core_req_valid | output | 1 | Request forwarded to the core |
| core_req_write | output | 1 | Forwarded direction |
| core_req_addr | output | ADDR_W | Forwarded address |
| core_req_accept | input | 1 | Core accepts the forwarded request |
| pwr_deep_down | input | 1 | Memory is in deep power-down |
| win_lo | input | NUM_INIT*ADDR_W | Lowest legal address for each initiator |
| win_hi | input | NUM_INIT*ADDR_W | Highest legal address for each initiator |
| cfg_timeout | input | CNT_W | Accept window in cycles, 0 = off |
| sw_clr | input | 1 | Write-one-to-clear of the error flag |
| err_valid | output | 1 | Sticky error-present flag |
| err_kind | output | 2 | 01 power-down, 10 out of window, 11 timeout |
| err_addr | output | ADDR_W | Address of the latest out-of-window access |

## Verification
The in-line assertions check several rules on every cycle. A power-down request is never forwarded and is always completed with an error. Every core accept is passed back to the requester. The error flag only falls on a clear, and a set flag never shows kind 00. The captured address moves only on an out-of-window event, and a timeout never fires while the window is disabled. The directed scenarios are needed for the rest: the exact cycle a timeout fires relative to an accept, the inclusive window bounds, the overwrite by a later illegal access, and the error-beats-clear collision.

// File: rtl/mreq_err_pkg.sv
package mreq_err_pkg;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'b00,
        KIND_PWR   = 2'b01,
        KIND_RANGE = 2'b10,
        KIND_TMO   = 2'b11
    } err_kind_e;

endpackage

// File: rtl/mreq_addr_window.sv
module mreq_addr_window #(
    parameter int ADDR_W   = 16,
    parameter int NUM_INIT = 4,
    parameter int ID_W     = 2
) (
    input  logic [ID_W-1:0]            init_id,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [NUM_INIT*ADDR_W-1:0] lo_flat,
    input  logic [NUM_INIT*ADDR_W-1:0] hi_flat,
    output logic                       in_window
);

    logic [NUM_INIT-1:0] hit;

    for (genvar g = 0; g < NUM_INIT; g++) begin : g_win
        logic [ADDR_W-1:0] lo_g;
        logic [ADDR_W-1:0] hi_g;
        assign lo_g   = lo_flat[g*ADDR_W +: ADDR_W];
        assign hi_g   = hi_flat[g*ADDR_W +: ADDR_W];
        assign hit[g] = (addr >= lo_g) && (addr <= hi_g);
    end

    always_comb begin
        in_window = 1'b0;
        for (int i = 0; i < NUM_INIT; i++) begin
            if (init_id == ID_W'(i)) begin
                in_window = hit[i];
            end
        end
    end

endmodule

// File: rtl/mreq_accept_timer.sv
module mreq_accept_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_accept,
    input  logic [CNT_W-1:0] cfg_limit,
    output logic             first_cycle,
    output logic             timeout_evt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fired;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        st_d        = st_q;
        timeout_evt = 1'b0;
        first_cycle = req_valid && (st_q.cnt == '0);
        cnt_inc     = (st_q.cnt != CNT_MAX) ? st_q.cnt + 1'b1 : st_q.cnt;
        if (req_valid && !req_accept) begin
            if (!st_q.fired) begin
                st_d.cnt = cnt_inc;
                if ((cfg_limit != '0) && (cnt_inc == cfg_limit)) begin
                    timeout_evt = 1'b1;
                    st_d.fired  = 1'b1;
                end
            end
        end else begin
            st_d.cnt   = '0;
            st_d.fired = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6
    tmo_needs_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_evt |-> (cfg_limit != '0));

    // R5
    accept_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_accept) |=> (st_q.cnt == '0 && !st_q.fired));

endmodule

// File: rtl/mreq_err_capture.sv
module mreq_err_capture
    import mreq_err_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_pwr,
    input  logic              evt_range,
    input  logic              evt_tmo,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic              sw_clr,
    output logic              err_valid,
    output logic [1:0]        err_kind,
    output logic [ADDR_W-1:0] err_addr
);

    typedef struct packed {
        logic              valid;
        err_kind_e         kind;
        logic [ADDR_W-1:0] addr;
    } cap_state_t;

    cap_state_t cs_d, cs_q;
    logic       any_evt;

    always_comb begin
        cs_d    = cs_q;
        any_evt = evt_pwr || evt_range || evt_tmo;
        if (sw_clr) begin
            cs_d.valid = 1'b0;
        end
        if (any_evt) begin
            cs_d.valid = 1'b1;
        end
        if (evt_pwr) begin
            cs_d.kind = KIND_PWR;
        end else if (evt_range) begin
            cs_d.kind = KIND_RANGE;
            cs_d.addr = evt_addr;
        end else if (evt_tmo) begin
            cs_d.kind = KIND_TMO;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= '{valid: 1'b0, kind: KIND_NONE, addr: '0};
        end else begin
            cs_q <= cs_d;
        end
    end

    assign err_valid = cs_q.valid;
    assign err_kind  = cs_q.kind;
    assign err_addr  = cs_q.addr;

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && !sw_clr) |=> err_valid);

    // R7
    kind_set_when_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (err_kind != 2'b00));

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_range |=> $stable(err_addr));

endmodule

// File: rtl/mreq_err_guard.sv
module mreq_err_guard #(
    parameter int ADDR_W   = 16,
    parameter int NUM_INIT = 4,
    parameter int ID_W     = 2,
    parameter int CNT_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       up_req_valid,
    input  logic                       up_req_write,
    input  logic [ADDR_W-1:0]          up_req_addr,
    input  logic [ID_W-1:0]            up_req_init,
    output logic                       up_req_accept,
    output logic                       up_resp_err,
    output logic                       core_req_valid,
    output logic                       core_req_write,
    output logic [ADDR_W-1:0]          core_req_addr,
    input  logic                       core_req_accept,
    input  logic                       pwr_deep_down,
    input  logic [NUM_INIT*ADDR_W-1:0] win_lo,
    input  logic [NUM_INIT*ADDR_W-1:0] win_hi,
    input  logic [CNT_W-1:0]           cfg_timeout,
    input  logic                       sw_clr,
    output logic                       err_valid,
    output logic [1:0]                 err_kind,
    output logic [ADDR_W-1:0]          err_addr
);

    logic first_cycle;
    logic timeout_evt;
    logic in_window;
    logic pwr_hit;
    logic range_hit;

    mreq_addr_window #(
        .ADDR_W   (ADDR_W),
        .NUM_INIT (NUM_INIT),
        .ID_W     (ID_W)
    ) win_i (
        .init_id   (up_req_init),
        .addr      (up_req_addr),
        .lo_flat   (win_lo),
        .hi_flat   (win_hi),
        .in_window (in_window)
    );

    mreq_accept_timer #(
        .CNT_W (CNT_W)
    ) tmr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (up_req_valid),
        .req_accept  (up_req_accept),
        .cfg_limit   (cfg_timeout),
        .first_cycle (first_cycle),
        .timeout_evt (timeout_evt)
    );

    always_comb begin
        pwr_hit        = first_cycle && pwr_deep_down;
        range_hit      = first_cycle && !pwr_deep_down && !in_window;
        core_req_valid = up_req_valid && !pwr_hit;
        core_req_write = up_req_write;
        core_req_addr  = up_req_addr;
        up_resp_err    = pwr_hit;
        up_req_accept  = pwr_hit || (core_req_valid && core_req_accept);
    end

    mreq_err_capture #(
        .ADDR_W (ADDR_W)
    ) cap_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_pwr   (pwr_hit),
        .evt_range (range_hit),
        .evt_tmo   (timeout_evt),
        .evt_addr  (up_req_addr),
        .sw_clr    (sw_clr),
        .err_valid (err_valid),
        .err_kind  (err_kind),
        .err_addr  (err_addr)
    );

    // R2
    pwr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req_valid && pwr_deep_down && first_cycle)
            |-> (!core_req_valid && up_req_accept && up_resp_err));

    // R2
    pwr_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_resp_err |=> (err_valid && err_kind == 2'b01));

    // R1
    accept_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req_valid && core_req_accept) |-> up_req_accept);

endmodule

// File: tb/mreq_err_guard_tb_top.sv
module mreq_err_guard_tb_top;

    localparam int AW = 16;
    localparam int NI = 4;
    localparam int IW = 2;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          up_req_valid = 1'b0;
    logic          up_req_write = 1'b0;
    logic [AW-1:0] up_req_addr = '0;
    logic [IW-1:0] up_req_init = '0;
    logic          up_req_accept;
    logic          up_resp_err;
    logic          core_req_valid;
    logic          core_req_write;
    logic [AW-1:0] core_req_addr;
    logic          core_req_accept = 1'b0;
    logic          pwr_deep_down = 1'b0;
    logic [NI*AW-1:0] win_lo;
    logic [NI*AW-1:0] win_hi;
    logic [CW-1:0] cfg_timeout = '0;
    logic          sw_clr = 1'b0;
    logic          err_valid;
    logic [1:0]    err_kind;
    logic [AW-1:0] err_addr;

    int n_vec = 0;
    int n_bad = 0;

    // windows: init0 1000..1FFF, init1 2000..2FFF, init2 0000..FFFF, init3 8000..80FF
    assign win_lo = {16'h8000, 16'h0000, 16'h2000, 16'h1000};
    assign win_hi = {16'h80FF, 16'hFFFF, 16'h2FFF, 16'h1FFF};

    always #10 clk = ~clk;

    mreq_err_guard #(.ADDR_W(AW), .NUM_INIT(NI), .ID_W(IW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .up_req_valid(up_req_valid), .up_req_write(up_req_write),
        .up_req_addr(up_req_addr), .up_req_init(up_req_init),
        .up_req_accept(up_req_accept), .up_resp_err(up_resp_err),
        .core_req_valid(core_req_valid), .core_req_write(core_req_write),
        .core_req_addr(core_req_addr), .core_req_accept(core_req_accept),
        .pwr_deep_down(pwr_deep_down), .win_lo(win_lo), .win_hi(win_hi),
        .cfg_timeout(cfg_timeout), .sw_clr(sw_clr),
        .err_valid(err_valid), .err_kind(err_kind), .err_addr(err_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [IW-1:0] id, input logic [AW-1:0] a,
                         input logic wr, input logic acc);
        @(negedge clk);
        up_req_valid    = 1'b1;
        up_req_init     = id;
        up_req_addr     = a;
        up_req_write    = wr;
        core_req_accept = acc;
        sw_clr          = 1'b0;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        up_req_valid    = 1'b0;
        core_req_accept = 1'b0;
        sw_clr          = 1'b0;
        #1;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        up_req_valid = 1'b0;
        sw_clr       = 1'b1;
        @(negedge clk);
        sw_clr       = 1'b0;
        #1;
        chk("R7 cleared", err_valid, 0);
    endtask

    task automatic t_reset();
        chk("R8 valid", err_valid, 0);
        chk("R8 kind", err_kind, 0);
        chk("R8 addr", err_addr, 0);
    endtask

    task automatic t_legal();
        drive(0, 16'h1234, 1'b1, 1'b1);
        chk("R1 core valid", core_req_valid, 1);
        chk("R1 core addr", core_req_addr, 16'h1234);
        chk("R1 core write", core_req_write, 1);
        chk("R1 accept", up_req_accept, 1);
        chk("R1 resp err", up_resp_err, 0);
        drive(1, 16'h2FFF, 1'b0, 1'b1);
        chk("R1 read dir", core_req_write, 0);
        idle();
        chk("R3 upper bound legal", err_valid, 0);
    endtask

    task automatic t_illegal();
        drive(1, 16'h3000, 1'b0, 1'b1);
        chk("R3 still forwarded", core_req_valid, 1);
        idle();
        chk("R3 valid", err_valid, 1);
        chk("R3 kind", err_kind, 2'b10);
        chk("R3 addr", err_addr, 16'h3000);
        drive(3, 16'h8100, 1'b0, 1'b1);
        idle();
        chk("R4 overwrite", err_addr, 16'h8100);
        clear_flag();
        drive(3, 16'h80FF, 1'b1, 1'b1);
        idle();
        chk("R3 inclusive hi", err_valid, 0);
        chk("R4 legal keeps addr", err_addr, 16'h8100);
        drive(0, 16'h0FFF, 1'b1, 1'b1);
        idle();
        chk("R3 below lo", err_addr, 16'h0FFF);
        clear_flag();
    endtask

    task automatic t_power();
        pwr_deep_down = 1'b1;
        drive(0, 16'h1100, 1'b0, 1'b0);
        chk("R2 accept", up_req_accept, 1);
        chk("R2 resp err", up_resp_err, 1);
        chk("R2 not forwarded", core_req_valid, 0);
        idle();
        pwr_deep_down = 1'b0;
        chk("R2 kind", err_kind, 2'b01);
        chk("R4 pwr keeps addr", err_addr, 16'h0FFF);
        clear_flag();
    endtask

    task automatic t_timeout();
        cfg_timeout = 8'd4;
        for (int i = 0; i < 3; i++) drive(2, 16'h4000, 1'b0, 1'b0);
        drive(2, 16'h4000, 1'b0, 1'b1);
        idle();
        chk("R5 accept in Tth cycle", err_valid, 0);
        for (int i = 0; i < 3; i++) drive(2, 16'h4444, 1'b0, 1'b0);
        chk("R5 not yet", err_valid, 0);
        drive(2, 16'h4444, 1'b0, 1'b0);
        @(negedge clk);
        #1;
        chk("R5 kind", err_kind, 2'b11);
        chk("R5 valid", err_valid, 1);
        chk("R4 tmo keeps addr", err_addr, 16'h0FFF);
        sw_clr = 1'b1;
        drive(2, 16'h4444, 1'b0, 1'b0);
        drive(2, 16'h4444, 1'b0, 1'b0);
        drive(2, 16'h4444, 1'b0, 1'b1);
        idle();
        chk("R5 once per request", err_valid, 0);
    endtask

    task automatic t_disabled();
        cfg_timeout = 8'd0;
        for (int i = 0; i < 300; i++) drive(2, 16'h5000, 1'b1, 1'b0);
        drive(2, 16'h5000, 1'b1, 1'b1);
        idle();
        chk("R6 no timeout", err_valid, 0);
    endtask

    task automatic t_collide();
        drive(1, 16'h9000, 1'b0, 1'b1);
        sw_clr = 1'b1;
        idle();
        chk("R7 error beats clear", err_valid, 1);
        chk("R7 kind latest", err_kind, 2'b10);
        clear_flag();
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_legal();
                t_illegal();
                t_power();
                t_timeout();
                t_disabled();
                t_collide();
            end
            begin
                repeat (20000) @(posedge clk);
                n_vec++;
                n_bad++;
                $display("FAIL watchdog: actual expired expected done");
            end
        join_any
        disable fork;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule